// File: doc/BRIEF.md
# Multi-cycle program counter and next-address unit

This block owns the program counter of a processor that runs each instruction over several short steps (fetch, decode, execute, memory, write-back) and picks the value the counter takes next. The controller tells the block which step is under way. In the fetch step the block moves the counter one word forward. In the decode step it works out the branch destination and holds it in a register. In the execute step it may overwrite the counter with that destination or with a jump address.

The jump address uses no adder. It is pure wiring: the upper four bits of the already-advanced counter, the 26-bit address field of the instruction, and two zero bits from a fixed left shift by two. The branch destination is the advanced counter plus the sign-extended 16-bit offset times four. It is loaded only when the ALU reports that the compared operands are equal. The write enable of the counter register is brought out so the controller and the checks can follow each update.

Top module: `pcu_next_pc`

## Requirements
- R1: While `rst_n` is low the counter reads 0x00000000, and it still reads 0 in the first cycle after reset is released.
- R2: When `step_i` is 0 (fetch), `pc_we_o` is high and at the next clock edge the counter becomes its old value plus 4, wrapping modulo 2^32 (0xFFFFFFFC advances to 0).
- R3: When `step_i` is 1 (decode), 3 (memory), 4 (write-back) or an unused code 5 to 7, `pc_we_o` is low and the counter keeps its value.
- R4: When `step_i` is 2 (execute) and instruction bits 31:26 equal 000010 (jump), `pc_we_o` is high and the counter becomes {counter[31:28], instruction[25:0], 2'b00}. The upper four bits come from the counter as already advanced in fetch.
- R5: When `step_i` is 2, bits 31:26 equal 000100 (branch-if-equal) and `alu_zero_i` is 1, `pc_we_o` is high and the counter becomes the advanced counter plus the sign-extended instruction[15:0] shifted left by two. The instruction word is held unchanged from decode through execute. Negative offsets move the counter backward.
- R6: A branch-if-equal in execute with `alu_zero_i` at 0 leaves the counter unchanged and keeps `pc_we_o` low.
- R7: In execute, any other opcode leaves the counter unchanged and keeps `pc_we_o` low, whatever the value of `alu_zero_i`.
- R8: With the default parameters, `alu_result_i` has no effect on the counter or on `pc_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 3 | Current step from the controller: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back |
| instr_i | input | 32 | Instruction word held by the instruction register |
| alu_zero_i | input | 1 | ALU equal/zero flag for the branch compare |
| alu_result_i | input | 32 | ALU result, used only when the branch destination is taken from the ALU |
| pc_o | output | 32 | Current program counter |
| pc_we_o | output | 1 | Counter write enable for this cycle |

## Verification
The bound checker follows, on every cycle, the step-by-step rules for the counter: the increment in fetch, holding in the quiet steps, the wired jump address, the branch destination, holding on a branch that is not taken, and the write enable matching the internal update events. Other behaviours come only from the bench's instruction sequences. These are the wrap past 0xFFFFFFFC, backward branches that cross address zero, a jump whose upper bits must come from the advanced counter rather than the old one, and a scrambled ALU result that must be ignored.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    STEP_FETCH  = 3'd0,
    STEP_DECODE = 3'd1,
    STEP_EXEC   = 3'd2,
    STEP_MEM    = 3'd3,
    STEP_WBACK  = 3'd4
  } step_e;

  typedef enum logic [1:0] {
    NPC_HOLD   = 2'd0,
    NPC_SEQ    = 2'd1,
    NPC_BRANCH = 2'd2,
    NPC_JUMP   = 2'd3
  } npc_sel_e;

  localparam logic [5:0] OPC_BEQ  = 6'b000100;
  localparam logic [5:0] OPC_JUMP = 6'b000010;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [2:0]       step_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             alu_zero_i,
  output npc_sel_e         sel_o,
  output logic             cap_en_o,
  output logic             fetch_fire_o,
  output logic             jump_fire_o,
  output logic             br_fire_o
);

  step_e step;
  logic  is_jump;
  logic  is_beq;

  assign step    = step_e'(step_i);
  assign is_jump = (opcode_i == OPC_W'(OPC_JUMP));
  assign is_beq  = (opcode_i == OPC_W'(OPC_BEQ));

  always_comb begin
    sel_o = NPC_HOLD;
    case (step)
      STEP_FETCH: sel_o = NPC_SEQ;
      STEP_EXEC: begin
        if (is_jump)                   sel_o = NPC_JUMP;
        else if (is_beq && alu_zero_i) sel_o = NPC_BRANCH;
      end
      default: sel_o = NPC_HOLD;
    endcase
  end

  assign cap_en_o     = (step == STEP_DECODE);
  assign fetch_fire_o = (sel_o == NPC_SEQ);
  assign jump_fire_o  = (sel_o == NPC_JUMP);
  assign br_fire_o    = (sel_o == NPC_BRANCH);

endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int ADDR_W     = 32,
  parameter int JF_W       = 26,
  parameter int IMM_W      = 16,
  parameter bit BR_FROM_ALU = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [JF_W-1:0]   field_i,
  input  logic [ADDR_W-1:0] alu_result_i,
  output logic [ADDR_W-1:0] seq_addr_o,
  output logic [ADDR_W-1:0] jump_addr_o,
  output logic [ADDR_W-1:0] br_addr_o
);

  localparam int UP_W  = ADDR_W - JF_W - 2;
  localparam int EXT_W = ADDR_W - IMM_W;

  function automatic logic [ADDR_W-1:0] f_seq(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(4);
  endfunction

  function automatic logic [ADDR_W-1:0] f_shl2(input logic [ADDR_W-1:0] v);
    return {v[ADDR_W-3:0], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] f_jump(input logic [ADDR_W-1:0] pc,
                                               input logic [JF_W-1:0]   fld);
    return {pc[ADDR_W-1 -: UP_W], fld, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] f_sext(input logic [IMM_W-1:0] imm);
    return {{EXT_W{imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [ADDR_W-1:0] f_branch(input logic [ADDR_W-1:0] pc,
                                                 input logic [IMM_W-1:0]  imm);
    return pc + f_shl2(f_sext(imm));
  endfunction

  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] tgt_d;

  assign seq_addr_o  = f_seq(pc_i);
  assign jump_addr_o = f_jump(pc_i, field_i);
  assign br_addr_o   = tgt_q;

  generate
    if (BR_FROM_ALU) begin : g_alu_tgt
      assign tgt_d = alu_result_i;
    end else begin : g_own_tgt
      logic unused_alu_result;
      assign unused_alu_result = ^alu_result_i;
      assign tgt_d = f_branch(pc_i, field_i[IMM_W-1:0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tgt_q <= '0;
    else if (cap_en_i) tgt_q <= tgt_d;
  end

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RESET_ADDR;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
  import pcu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int JF_W        = 26,
  parameter int IMM_W       = 16,
  parameter int OPC_W       = 6,
  parameter bit BR_FROM_ALU = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] instr_i,
  input  logic              alu_zero_i,
  input  logic [ADDR_W-1:0] alu_result_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_we_o
);

  npc_sel_e          sel;
  logic              cap_en;
  logic              fetch_fire;
  logic              jump_fire;
  logic              br_fire;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] jump_addr;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] pc_d;

  pcu_decode #(.OPC_W(OPC_W)) u_dec (
    .step_i       (step_i),
    .opcode_i     (instr_i[ADDR_W-1 -: OPC_W]),
    .alu_zero_i   (alu_zero_i),
    .sel_o        (sel),
    .cap_en_o     (cap_en),
    .fetch_fire_o (fetch_fire),
    .jump_fire_o  (jump_fire),
    .br_fire_o    (br_fire)
  );

  pcu_target #(
    .ADDR_W      (ADDR_W),
    .JF_W        (JF_W),
    .IMM_W       (IMM_W),
    .BR_FROM_ALU (BR_FROM_ALU)
  ) u_tgt (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en_i     (cap_en),
    .pc_i         (pc_o),
    .field_i      (instr_i[JF_W-1:0]),
    .alu_result_i (alu_result_i),
    .seq_addr_o   (seq_addr),
    .jump_addr_o  (jump_addr),
    .br_addr_o    (br_addr)
  );

  always_comb begin
    case (sel)
      NPC_SEQ:    pc_d = seq_addr;
      NPC_JUMP:   pc_d = jump_addr;
      NPC_BRANCH: pc_d = br_addr;
      default:    pc_d = pc_o;
    endcase
  end

  assign pc_we_o = (sel != NPC_HOLD);

  pcu_pc_reg #(.ADDR_W(ADDR_W), .RESET_ADDR('0)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (pc_we_o),
    .d_i   (pc_d),
    .q_o   (pc_o)
  );

endmodule

// File: rtl/pcu_next_pc_chk.sv
module pcu_next_pc_chk #(
  parameter int ADDR_W = 32,
  parameter int JF_W   = 26,
  parameter int IMM_W  = 16,
  parameter int OPC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        step_i,
  input logic [ADDR_W-1:0] instr_i,
  input logic              alu_zero_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              pc_we_o,
  input logic              fetch_fire,
  input logic              jump_fire,
  input logic              br_fire
);

  localparam int UP_W = ADDR_W - JF_W - 2;

  logic [OPC_W-1:0] opc;
  logic             in_exec;
  logic             quiet;
  logic             op_j;
  logic             op_b;
  logic [ADDR_W-1:0] br_off;

  assign opc     = instr_i[ADDR_W-1 -: OPC_W];
  assign in_exec = (step_i == 3'd2);
  assign quiet   = (step_i != 3'd0) && !in_exec;
  assign op_j    = (opc == OPC_W'(6'b000010));
  assign op_b    = (opc == OPC_W'(6'b000100));
  assign br_off  = ADDR_W'($signed(instr_i[IMM_W-1:0])) <<< 2;

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_o == '0);

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == 3'd0) |=> pc_o == $past(pc_o) + ADDR_W'(4));

  p_fetch_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == 3'd0) |-> pc_we_o);

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(pc_o));

  p_quiet_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !pc_we_o);

  p_jump_wire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op_j) |=>
      pc_o == {$past(pc_o[ADDR_W-1 -: UP_W]), $past(instr_i[JF_W-1:0]), 2'b00});

  p_branch_tgt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op_b && alu_zero_i) |=> pc_o == $past(pc_o) + $past(br_off));

  p_branch_nt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op_b && !alu_zero_i) |=> $stable(pc_o));

  p_other_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !op_b && !op_j) |=> $stable(pc_o));

  p_we_events_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_o == (fetch_fire || jump_fire || br_fire));

  p_single_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_fire, jump_fire, br_fire}));

endmodule

bind pcu_next_pc pcu_next_pc_chk #(
  .ADDR_W (ADDR_W),
  .JF_W   (JF_W),
  .IMM_W  (IMM_W),
  .OPC_W  (OPC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .instr_i    (instr_i),
  .alu_zero_i (alu_zero_i),
  .pc_o       (pc_o),
  .pc_we_o    (pc_we_o),
  .fetch_fire (fetch_fire),
  .jump_fire  (jump_fire),
  .br_fire    (br_fire)
);

// File: tb/tb_pcu_next_pc.sv
module tb_pcu_next_pc;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  step_i = 3'd3;
  logic [31:0] instr_i = '0;
  logic        alu_zero_i = 1'b0;
  logic [31:0] alu_result_i = '0;
  logic [31:0] pc_o;
  logic        pc_we_o;

  always #(CLK_P/2) clk = ~clk;

  pcu_next_pc dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .instr_i      (instr_i),
    .alu_zero_i   (alu_zero_i),
    .alu_result_i (alu_result_i),
    .pc_o         (pc_o),
    .pc_we_o      (pc_we_o)
  );

  typedef struct {
    string       req;
    logic [31:0] pc;
    logic        we;
  } item_t;

  item_t q[$];
  int n_cmp  = 0;
  int n_bad  = 0;
  logic [31:0] m_pc  = '0;
  logic [31:0] m_tgt = '0;

  function automatic logic [31:0] mk_jump(input logic [25:0] f);
    return {6'b000010, f};
  endfunction

  function automatic logic [31:0] mk_beq(input logic [15:0] imm);
    return {6'b000100, 10'h0, imm};
  endfunction

  // Driver: applies one step just after a rising edge and pushes what the
  // outputs must show during that cycle, then advances the reference model.
  task automatic drive(input logic [2:0] st, input logic [31:0] ins,
                       input logic z, input logic [31:0] res, input string req);
    logic        we;
    logic [31:0] nxt;
    @(posedge clk);
    #1;
    step_i = st; instr_i = ins; alu_zero_i = z; alu_result_i = res;
    we  = 1'b0;
    nxt = m_pc;
    if (st == 3'd0) begin
      we = 1'b1; nxt = m_pc + 32'd4;
    end else if (st == 3'd1) begin
      m_tgt = m_pc + (32'($signed(ins[15:0])) * 32'd4);
    end else if (st == 3'd2) begin
      if (ins[31:26] == 6'd2) begin
        we = 1'b1; nxt = (m_pc & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) << 2);
      end else if (ins[31:26] == 6'd4 && z) begin
        we = 1'b1; nxt = m_tgt;
      end
    end
    q.push_back('{req: req, pc: m_pc, we: we});
    m_pc = nxt;
  endtask

  // Monitor: pops one expected item per cycle at the falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (pc_o !== it.pc || pc_we_o !== it.we) begin
        n_bad++;
        $display("FAIL %s: pc=%h we=%b expected pc=%h we=%b",
                 it.req, pc_o, pc_we_o, it.pc, it.we);
      end
    end
  end

  task automatic run_instr(input logic [31:0] ins, input logic z,
                           input logic [31:0] res, input int tail, input string req);
    drive(3'd0, ins, 1'b0, 32'hDEAD_0000, "R2");
    drive(3'd1, ins, 1'b0, 32'hDEAD_0001, "R3");
    drive(3'd2, ins, z, res, req);
    if (tail > 0) drive(3'd3, ins, z, res, "R3");
    if (tail > 1) drive(3'd4, ins, z, res, "R3");
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (pc_o !== 32'h0) begin
      n_bad++;
      $display("FAIL R1: pc=%h expected 00000000 in reset", pc_o);
    end
    rst_n = 1'b1;

    // R1: first cycle after release, quiet step shows address 0
    drive(3'd3, 32'h0, 1'b0, 32'h0, "R1");
    // R7 and R8: register-register op, zero flag set, scrambled ALU value
    run_instr(32'h0000_0020, 1'b1, 32'h1234_5678, 2, "R7");
    // R6: branch with operands unequal
    run_instr(mk_beq(16'h0007), 1'b0, 32'hFFFF_FFF0, 0, "R6");
    // R5 and R8: forward branch taken, ALU result unrelated to the target
    run_instr(mk_beq(16'h0005), 1'b1, 32'h0BAD_0BAD, 0, "R5");
    // R4: jump within region zero
    run_instr(mk_jump(26'h0000123), 1'b0, 32'h0, 0, "R4");
    // R3: load-like op walks all five steps, plus unused step codes
    run_instr({6'b100011, 26'h0}, 1'b1, 32'h0, 2, "R3");
    drive(3'd5, 32'h0, 1'b1, 32'h0, "R3");
    drive(3'd7, mk_jump(26'h1), 1'b1, 32'h0, "R3");
    // jump back to 0, then backward branch across zero to 0xFFFFFFF8 (R5)
    run_instr(mk_jump(26'h0), 1'b0, 32'h0, 0, "R4");
    run_instr(mk_beq(16'hFFFD), 1'b1, 32'h0, 0, "R5");
    // jump in the top region keeps upper nibble F (R4)
    run_instr(mk_jump(26'h0000155), 1'b0, 32'h0, 0, "R4");
    // back to 0xFFFFFFF8, hold through an add, then fetch wraps to 0 (R2)
    run_instr(mk_jump(26'h3FF_FFFE), 1'b0, 32'h0, 0, "R4");
    run_instr(32'h0000_0020, 1'b0, 32'h0, 1, "R7");
    // fetch at 0xFFFFFFFC wraps to 0; jump takes upper bits from advanced PC
    run_instr(mk_jump(26'h3FF_FFFF), 1'b0, 32'h0, 0, "R4");
    // from 0x0FFFFFFC fetch crosses into region 1, jump keeps nibble 1
    run_instr(mk_jump(26'h0000001), 1'b0, 32'h0, 0, "R4");
    // R6 with a taken-looking ALU result
    run_instr(mk_beq(16'h8000), 1'b0, 32'h0, 1, "R6");
    // R5: most negative offset
    run_instr(mk_beq(16'h8000), 1'b1, 32'h0, 0, "R5");
    drive(3'd3, 32'h0, 1'b0, 32'h0, "R5");
    drive(3'd3, 32'h0, 1'b0, 32'h0, "R3");

    @(posedge clk);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule